// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers device interrupt requests into one interrupt line for a processor. It is built from two identical eight-line units. The lower-level unit's summary output feeds one input slot of the upper-level unit, so fifteen device lines are usable. Each unit latches rising edges on its lines, filters them through an 8-bit mask and picks the winner by fixed priority. Lower line numbers win.

The processor answers a raised `int_o` with a one-cycle `inta_i` strobe. In the following cycle the block presents an 8-bit vector with `vec_valid_o` high. The upper five bits of the vector are the base of the unit that owns the line, and the lower three bits are the line number. The serviced line then stays in service, and it blocks requests of its own and lower priority until software writes an end-of-interrupt command. A request from the lower-level unit needs that command written to both units.

Software programs the units through a write-only register bus with four locations. `reg_unit_i` selects the unit (0 = upper, 1 = lower) and `reg_port_i` selects the port (0 = command, 1 = data). The acknowledge strobe is the whole handshake for the vector. The processor does not apply back-pressure, and the vector is offered for exactly one cycle.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset `int_o` and `vec_valid_o` are low, all mask bits are clear, and the vector bases are 0 (upper) and 8 (lower), so vectors fall in 0 to 15.
- R2: A low-to-high transition on an unmasked device line raises `int_o`. A line held high after its request has been serviced does not raise it again.
- R3: Priority is fixed: line 0 of a unit is highest and line 7 is lowest. All lower-unit lines rank at upper slot 2, above upper lines 3 to 7 and below upper lines 0 and 1.
- R4: A data-port write loads that unit's mask. A set bit N stops line N from being selected. A request latched while masked is delivered once the bit is cleared.
- R5: The vector is registered on the cycle in which `inta_i` is high. `vec_valid_o` is high with `vec_o` = {base[7:3], line[2:0]} in the next cycle only.
- R6: A command-port write of 0x10 arms a base load. The next data-port write to that unit loads base bits 7:3 (bits 2:0 are ignored) and leaves the mask unchanged.
- R7: An acknowledged line enters the in-service state. Until end-of-interrupt, requests of equal or lower priority in that unit do not raise `int_o`, while higher-priority requests still do.
- R8: A command-port write of 0x20 clears the highest-priority in-service bit of that unit.
- R9: A lower-unit interrupt occupies slot 2 of the upper unit. No further interrupt at or below slot 2 is raised until end-of-interrupt has been written to both units. The upper unit's own device input at slot 2 is ignored.
- R10: An acknowledge while nothing is deliverable returns the upper base plus 7 and changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_irq_i | input | 8 | Upper-unit device request lines (bit 2 unused) |
| sec_irq_i | input | 8 | Lower-unit device request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_unit_i | input | 1 | Unit select: 0 upper, 1 lower |
| reg_port_i | input | 1 | Port select: 0 command, 1 data |
| reg_wdata_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | One-cycle interrupt acknowledge |
| vec_valid_o | output | 1 | Vector valid, the cycle after acknowledge |
| vec_o | output | 8 | Interrupt vector |

## Verification
The assertions check the following on every cycle:
- The in-service set changes only on acknowledge or end-of-interrupt.
- An accepted acknowledge adds exactly one in-service bit, and that bit was not masked.
- End-of-interrupt removes exactly one bit.
- The vector-valid flag follows the acknowledge by one cycle, and the vector always carries one of the two programmed bases.

Only the directed scenarios can show the following:
- Which line wins between simultaneous requests.
- The exact vector numbers.
- That end-of-interrupt releases the highest in-service line rather than another one.
- That a cascaded request stays blocked until both units have received end-of-interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] CMD_EOI = 8'h20;
  localparam int CMD_ARM_BIT = 4;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
  import irqc_pkg::*;
#(
  parameter int N = 8,
  parameter int VEC_W = 8,
  parameter int RESET_BASE = 0,
  localparam int IW = $clog2(N),
  localparam int BW = VEC_W - IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             wr_cmd_i,
  input  logic             wr_data_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic [IW-1:0]    sel_o,
  output logic [BW-1:0]    base_o
);
  logic [N-1:0]  req_q, irr, isr, imr;
  logic [BW-1:0] base_q;
  logic          arm_q;
  logic          cand_found, isr_found;
  logic [IW-1:0] cand_idx, isr_idx;
  logic [N-1:0]  cand, rise, take_mask, eoi_mask;
  logic          eoi, ack_take;

  assign cand = irr & ~imr;
  assign rise = req_i & ~req_q;

  irqc_prio_enc #(.N(N)) u_cand_enc (.vec_i(cand), .found_o(cand_found), .idx_o(cand_idx));
  irqc_prio_enc #(.N(N)) u_isr_enc  (.vec_i(isr),  .found_o(isr_found),  .idx_o(isr_idx));

  assign int_o    = cand_found && (!isr_found || (cand_idx < isr_idx));
  assign sel_o    = cand_idx;
  assign base_o   = base_q;
  assign ack_take = ack_i && int_o;
  assign eoi      = wr_cmd_i && (wdata_i == CMD_EOI);

  always_comb begin
    take_mask = '0;
    eoi_mask  = '0;
    if (ack_take) take_mask[cand_idx] = 1'b1;
    if (eoi && isr_found) eoi_mask[isr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      irr    <= '0;
      isr    <= '0;
      imr    <= '0;
      base_q <= BW'(RESET_BASE >> IW);
      arm_q  <= 1'b0;
    end else begin
      req_q <= req_i;
      irr   <= (irr & ~take_mask) | rise;
      isr   <= (isr & ~eoi_mask) | take_mask;
      if (wr_cmd_i && wdata_i[CMD_ARM_BIT] && !eoi) arm_q <= 1'b1;
      if (wr_data_i) begin
        if (arm_q) begin
          base_q <= wdata_i[REG_W-1 -: BW];
          arm_q  <= 1'b0;
        end else begin
          imr <= wdata_i[N-1:0];
        end
      end
    end
  end

  AST_ISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !eoi) |=> (isr == $past(isr)));  // R7
  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));  // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr != '0) && !ack_i) |=> ($countones(isr) + 1 == $countones($past(isr))));  // R8
  AST_MASKED_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ((isr & ~$past(isr) & $past(imr)) == '0));  // R4
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int CASC_LINE = 2,
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  localparam int IW = $clog2(LINES),
  localparam int BW = VEC_W - IW,
  localparam int UNITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pri_irq_i,
  input  logic [LINES-1:0] sec_irq_i,
  input  logic             reg_wr_i,
  input  logic             reg_unit_i,
  input  logic             reg_port_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             int_o,
  input  logic             inta_i,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [LINES-1:0] u_req  [UNITS];
  logic             u_int  [UNITS];
  logic [IW-1:0]    u_sel  [UNITS];
  logic [BW-1:0]    u_base [UNITS];
  logic             u_ack  [UNITS];
  logic [VEC_W-1:0] vec_d;
  logic             casc_hit;

  always_comb begin
    u_req[0] = pri_irq_i;
    u_req[0][CASC_LINE] = u_int[1];
    u_req[1] = sec_irq_i;
  end

  assign casc_hit = u_int[0] && (u_sel[0] == IW'(CASC_LINE));
  assign u_ack[0] = inta_i;
  assign u_ack[1] = inta_i && casc_hit;

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    irqc_unit #(
      .N(LINES), .VEC_W(VEC_W), .RESET_BASE(g * LINES)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (u_req[g]),
      .wr_cmd_i (reg_wr_i && (reg_unit_i == 1'(g)) && !reg_port_i),
      .wr_data_i(reg_wr_i && (reg_unit_i == 1'(g)) && reg_port_i),
      .wdata_i  (reg_wdata_i),
      .ack_i    (u_ack[g]),
      .int_o    (u_int[g]),
      .sel_o    (u_sel[g]),
      .base_o   (u_base[g])
    );
  end

  always_comb begin
    if (!u_int[0])     vec_d = {u_base[0], {IW{1'b1}}};
    else if (!casc_hit) vec_d = {u_base[0], u_sel[0]};
    else if (u_int[1])  vec_d = {u_base[1], u_sel[1]};
    else                vec_d = {u_base[1], {IW{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= inta_i;
      if (inta_i) vec_o <= vec_d;
    end
  end

  assign int_o = u_int[0];

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    inta_i |=> vec_valid_o);  // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_i |=> !vec_valid_o);  // R5
  AST_VEC_HAS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    inta_i |=> ((vec_o[VEC_W-1 -: BW] == $past(u_base[0])) ||
                (vec_o[VEC_W-1 -: BW] == $past(u_base[1]))));  // R6
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pri_irq = '0, sec_irq = '0;
  logic       reg_wr = 1'b0, reg_unit = 1'b0, reg_port = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       int_o, inta = 1'b0, vec_valid;
  logic [7:0] vec;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pri_irq_i(pri_irq), .sec_irq_i(sec_irq),
    .reg_wr_i(reg_wr), .reg_unit_i(reg_unit), .reg_port_i(reg_port),
    .reg_wdata_i(reg_wdata), .int_o(int_o), .inta_i(inta),
    .vec_valid_o(vec_valid), .vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input bit unit, input bit port, input logic [7:0] d);
    reg_wr = 1'b1; reg_unit = unit; reg_port = port; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic eoi(input bit unit);
    reg_write(unit, 1'b0, 8'h20);
  endtask

  task automatic ack_expect(input string req, input int exp);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk(vec_valid == 1'b1, req, int'(vec_valid), 1);
    chk(vec == 8'(exp), req, int'(vec), exp);
    @(negedge clk);
    chk(vec_valid == 1'b0, "R5", int'(vec_valid), 0);
  endtask

  task automatic chk_int(input string req, input bit exp);
    chk(int_o == exp, req, int'(int_o), int'(exp));
  endtask

  task automatic t_reset;
    chk_int("R1", 1'b0);
    chk(vec_valid == 1'b0, "R1", int'(vec_valid), 0);
    ack_expect("R10", 7);
    chk_int("R10", 1'b0);
  endtask

  task automatic t_default_bases;
    sec_irq[0] = 1'b1; wait_n(3);
    chk_int("R2", 1'b1);
    ack_expect("R1", 8);
    eoi(1'b1); eoi(1'b0);
    sec_irq[0] = 1'b0; wait_n(1);
    chk_int("R1", 1'b0);
  endtask

  task automatic t_program_bases;
    reg_write(1'b0, 1'b0, 8'h10); reg_write(1'b0, 1'b1, 8'h23);
    reg_write(1'b1, 1'b0, 8'h10); reg_write(1'b1, 1'b1, 8'h2F);
    pri_irq[0] = 1'b1; wait_n(3);
    ack_expect("R6", 32);
    eoi(1'b0); pri_irq[0] = 1'b0;
    pri_irq[1] = 1'b1; wait_n(3);
    chk_int("R6 mask untouched", 1'b1);
    ack_expect("R6", 33);
    eoi(1'b0); pri_irq[1] = 1'b0; wait_n(1);
  endtask

  task automatic t_priority;
    pri_irq[1] = 1'b1; pri_irq[0] = 1'b1; wait_n(3);
    ack_expect("R3", 32);
    chk_int("R7", 1'b0);
    eoi(1'b0);
    chk_int("R8", 1'b1);
    ack_expect("R3", 33);
    eoi(1'b0); pri_irq[1:0] = 2'b00;
    pri_irq[3] = 1'b1; sec_irq[5] = 1'b1; wait_n(3);
    ack_expect("R3 cascade slot", 45);
    eoi(1'b1); eoi(1'b0);
    chk_int("R3", 1'b1);
    ack_expect("R3", 35);
    eoi(1'b0); pri_irq[3] = 1'b0; sec_irq[5] = 1'b0; wait_n(1);
  endtask

  task automatic t_nesting;
    pri_irq[4] = 1'b1; wait_n(3);
    ack_expect("R7", 36);
    pri_irq[4] = 1'b0; wait_n(1); pri_irq[4] = 1'b1; wait_n(3);
    chk_int("R7 same level", 1'b0);
    pri_irq[1] = 1'b1; wait_n(3);
    chk_int("R7 higher", 1'b1);
    ack_expect("R7", 33);
    eoi(1'b0);
    chk_int("R8 highest cleared", 1'b0);
    eoi(1'b0);
    chk_int("R8", 1'b1);
    ack_expect("R8", 36);
    eoi(1'b0); wait_n(2);
    chk_int("R2 held level", 1'b0);
    pri_irq[4] = 1'b0; pri_irq[1] = 1'b0; wait_n(1);
  endtask

  task automatic t_mask;
    reg_write(1'b0, 1'b1, 8'h01);
    pri_irq[0] = 1'b1; wait_n(3);
    chk_int("R4 masked", 1'b0);
    reg_write(1'b0, 1'b1, 8'h00);
    chk_int("R4 unmasked", 1'b1);
    ack_expect("R4", 32);
    eoi(1'b0); pri_irq[0] = 1'b0; wait_n(1);
  endtask

  task automatic t_cascade;
    pri_irq[2] = 1'b1; wait_n(3);
    chk_int("R9 slot input ignored", 1'b0);
    pri_irq[2] = 1'b0;
    sec_irq[1] = 1'b1; sec_irq[6] = 1'b1; wait_n(3);
    ack_expect("R9", 41);
    eoi(1'b1); wait_n(3);
    chk_int("R9 one EOI", 1'b0);
    eoi(1'b0); wait_n(1);
    chk_int("R9 both EOI", 1'b1);
    ack_expect("R9", 46);
    eoi(1'b1); eoi(1'b0); wait_n(2);
    chk_int("R9", 1'b0);
    sec_irq = '0; wait_n(1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_default_bases();
    t_program_bases();
    t_priority();
    t_nesting();
    t_mask();
    t_cascade();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule